// File: doc/BRIEF.md
# One-Wire Bus Master

This block is the master of a single open-drain one-wire bus. A host starts one of three operations with a start strobe and an operation code. A reset operation pulls the bus low for a long interval, releases it, and checks whether any device answers by holding the line low. A touch-slot operation sends one bit and reads one bit in the same time slot. A touch-byte operation runs eight touch slots back to back.

In a touch slot the bit sent is the least significant bit of an internal working word, and the bit read is shifted into the top of that word. Writing a 1 leaves the line released, so a device can pull it low, and the slot works as a read. To read a byte, send 0xFF. To write a byte, send the data and ignore what comes back.

The bus pin is modelled as an active-high pull-down enable plus an input that the block synchronises. Every time interval is a whole number of microseconds multiplied by the `CLK_PER_US` parameter.

Top module: `owm_master`

## Requirements
- R1: After reset: `bus_oe`=0, `busy`=0, `done`=0, `dout`=0x00, `present`=0.
- R2: Op code 2'b00 (reset) sets `busy`. It then drives `bus_oe`=1 for exactly 480 µs and `bus_oe`=0 for exactly 480 µs, and then the block returns to idle.
- R3: A reset operation sets `present` to 1 if the bus is low about 64 µs after the release, and to 0 if it is high. Touch operations leave `present` unchanged.
- R4: Each touch slot lasts 68 µs and begins with `bus_oe`=1 for exactly 6 µs.
- R5: After those first 6 µs, a slot keeps `bus_oe` at the inverse of the bit being sent until 66 µs into the slot. It then releases the bus for a 2 µs recovery time.
- R6: Op code 2'b01 (single slot) sends `din[0]`. It ends with `dout` = {bus level sampled about 15 µs into the slot, `din[7:1]`}.
- R7: Op code 2'b10 (byte) runs eight slots that send `din[0]` first and `din[7]` last. It ends with `dout[i]` = the bus level sampled in slot i.
- R8: While `busy`=1, `start` is ignored, and so are changes to `op` and `din`. The operation in progress finishes with its own timing and result.
- R9: `done` is high for one cycle when an operation ends. In that cycle `busy`=0, and `dout` and `present` already hold the result.
- R10: A start strobe with op code 2'b11 does nothing: `busy`, `done`, `bus_oe`, `dout` and `present` all stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation strobe, accepted only while idle |
| op | input | 2 | Operation code: 00 reset, 01 slot, 10 byte, 11 none |
| din | input | 8 | Working word loaded when an operation starts |
| dout | output | 8 | Working word after the last completed touch operation |
| present | output | 1 | Result of the last reset operation (1 = device present) |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_oe | output | 1 | 1 pulls the bus low, 0 lets it float high |
| bus_in | input | 1 | Level on the bus |

## Verification
The hardest case to reach is one where the bit read back differs from the bit sent. This happens when the master releases the line and a device holds it low through the sampling point. The bench models the device with the bus as a wired-AND. It pulls the line low inside a window that opens after the slot's falling edge, following a per-bit response pattern, and it can also answer the reset with or without a presence pulse. The bench also raises a second start with a different operation and data in the middle of a byte operation, to show that this start is ignored.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_LOW,
    ST_RST_WAIT,
    ST_RST_REST,
    ST_SLOT_LOW,
    ST_SLOT_SAMPLE,
    ST_SLOT_HOLD,
    ST_SLOT_RECOVER
  } owm_state_e;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_SLOT  = 2'b01,
    OP_BYTE  = 2'b10,
    OP_NONE  = 2'b11
  } owm_op_e;

endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= 1'b1;
        else        chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/owm_phase_timer.sv
module owm_phase_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/owm_shift_reg.sv
module owm_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         shift_in,
  output logic [W-1:0] word,
  output logic         lsb
);

  logic [W-1:0] word_q;
  logic [W-1:0] word_d;
  logic         word_en;

  assign word_en = load | shift;

  always_comb begin
    word_d = word_q;
    if (load)       word_d = load_val;
    else if (shift) word_d = {shift_in, word_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  assign word = word_q;
  assign lsb  = word_q[0];

endmodule

// File: rtl/owm_master.sv
module owm_master
  import owm_pkg::*;
#(
  parameter int CLK_PER_US  = 50,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              present,
  output logic              busy,
  output logic              done,
  output logic              bus_oe,
  input  logic              bus_in
);

  // phase lengths in cycles; sample phases stretched by the synchronizer depth
  localparam int D_RST_LOW   = 480 * CLK_PER_US;
  localparam int D_RST_WAIT  = 64 * CLK_PER_US + SYNC_STAGES;
  localparam int D_RST_REST  = 416 * CLK_PER_US - SYNC_STAGES;
  localparam int D_SLOT_LOW  = 6 * CLK_PER_US;
  localparam int D_SLOT_SMP  = 9 * CLK_PER_US + SYNC_STAGES;
  localparam int D_SLOT_HOLD = 51 * CLK_PER_US - SYNC_STAGES;
  localparam int D_SLOT_REC  = 2 * CLK_PER_US;
  localparam int CW          = $clog2(D_RST_LOW + 1);
  localparam int BW          = $clog2(DATA_W + 1);

  localparam logic [CW-1:0] L_RST_LOW   = CW'(D_RST_LOW - 1);
  localparam logic [CW-1:0] L_RST_WAIT  = CW'(D_RST_WAIT - 1);
  localparam logic [CW-1:0] L_RST_REST  = CW'(D_RST_REST - 1);
  localparam logic [CW-1:0] L_SLOT_LOW  = CW'(D_SLOT_LOW - 1);
  localparam logic [CW-1:0] L_SLOT_SMP  = CW'(D_SLOT_SMP - 1);
  localparam logic [CW-1:0] L_SLOT_HOLD = CW'(D_SLOT_HOLD - 1);
  localparam logic [CW-1:0] L_SLOT_REC  = CW'(D_SLOT_REC - 1);
  localparam logic [BW-1:0] BITS_BYTE   = BW'(DATA_W);
  localparam logic [BW-1:0] BITS_ONE    = BW'(1);

  owm_state_e      state_q, state_d;
  owm_op_e         op_e;
  logic [BW-1:0]   bits_q, bits_d;
  logic            bits_en;
  logic            tx_q, tx_d, tx_en;
  logic            pres_q, pres_d, pres_en;
  logic            done_q, done_d;
  logic            tmr_load, tmr_expired;
  logic [CW-1:0]   tmr_val;
  logic            word_load, word_shift, word_lsb;
  logic [DATA_W-1:0] word;
  logic            rx_sync;

  assign op_e = owm_op_e'(op);

  owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (bus_in),
    .q     (rx_sync)
  );

  owm_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  owm_shift_reg #(.W(DATA_W)) u_word (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (word_load),
    .load_val (din),
    .shift    (word_shift),
    .shift_in (rx_sync),
    .word     (word),
    .lsb      (word_lsb)
  );

  // next-state logic
  always_comb begin
    state_d    = state_q;
    bits_d     = bits_q;
    bits_en    = 1'b0;
    word_load  = 1'b0;
    word_shift = 1'b0;
    pres_en    = 1'b0;
    pres_d     = ~rx_sync;
    tx_en      = 1'b0;
    tx_d       = word_lsb;
    done_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start && op_e != OP_NONE) begin
          if (op_e == OP_RESET) begin
            state_d = ST_RST_LOW;
          end else begin
            state_d   = ST_SLOT_LOW;
            word_load = 1'b1;
            bits_en   = 1'b1;
            bits_d    = (op_e == OP_BYTE) ? BITS_BYTE : BITS_ONE;
          end
        end
      end
      ST_RST_LOW:  if (tmr_expired) state_d = ST_RST_WAIT;
      ST_RST_WAIT: begin
        if (tmr_expired) begin
          state_d = ST_RST_REST;
          pres_en = 1'b1;
        end
      end
      ST_RST_REST: begin
        if (tmr_expired) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      ST_SLOT_LOW: begin
        if (tmr_expired) begin
          state_d = ST_SLOT_SAMPLE;
          tx_en   = 1'b1;
        end
      end
      ST_SLOT_SAMPLE: begin
        if (tmr_expired) begin
          state_d    = ST_SLOT_HOLD;
          word_shift = 1'b1;
        end
      end
      ST_SLOT_HOLD: if (tmr_expired) state_d = ST_SLOT_RECOVER;
      ST_SLOT_RECOVER: begin
        if (tmr_expired) begin
          bits_en = 1'b1;
          bits_d  = bits_q - 1'b1;
          if (bits_q == BITS_ONE) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_SLOT_LOW;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // timer reload on every phase change
  assign tmr_load = (state_d != state_q);

  always_comb begin
    unique case (state_d)
      ST_RST_LOW:      tmr_val = L_RST_LOW;
      ST_RST_WAIT:     tmr_val = L_RST_WAIT;
      ST_RST_REST:     tmr_val = L_RST_REST;
      ST_SLOT_LOW:     tmr_val = L_SLOT_LOW;
      ST_SLOT_SAMPLE:  tmr_val = L_SLOT_SMP;
      ST_SLOT_HOLD:    tmr_val = L_SLOT_HOLD;
      ST_SLOT_RECOVER: tmr_val = L_SLOT_REC;
      default:         tmr_val = '0;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bits_q <= '0;
    else if (bits_en) bits_q <= bits_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tx_q <= 1'b1;
    else if (tx_en) tx_q <= tx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pres_q <= 1'b0;
    else if (pres_en) pres_q <= pres_d;
  end

  // outputs
  always_comb begin
    unique case (state_q)
      ST_RST_LOW, ST_SLOT_LOW:      bus_oe = 1'b1;
      ST_SLOT_SAMPLE, ST_SLOT_HOLD: bus_oe = ~tx_q;
      default:                      bus_oe = 1'b0;
    endcase
  end

  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign dout    = word;
  assign present = pres_q;

endmodule

// File: rtl/owm_master_chk.sv
module owm_master_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        op,
  input logic              busy,
  input logic              done,
  input logic              bus_oe,
  input logic [DATA_W-1:0] dout,
  input logic              present
);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_bus_free_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_oe);

  assert_start_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && op != 2'b11) |=> busy);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (!start || op == 2'b11)) |=> ($stable(dout) && $stable(present) && !busy));

endmodule

bind owm_master owm_master_chk #(.DATA_W(DATA_W)) u_owm_master_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .op      (op),
  .busy    (busy),
  .done    (done),
  .bus_oe  (bus_oe),
  .dout    (dout),
  .present (present)
);

// File: tb/owm_master_test.sv
`timescale 1ns/1ps
module owm_master_test;

  localparam int C  = 2;
  localparam int SL = 68 * C;
  localparam int RT = 960 * C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] op = 2'b00;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       present, busy, done, bus_oe;
  logic       bus_in;

  // bench-side device configuration
  logic       dev_present = 1'b1;
  logic [7:0] dev_resp = 8'hFF;

  // reference model state
  bit         m_active = 0;
  bit         m_done = 0;
  bit         m_oe = 0;
  bit         m_pull = 0;
  int         m_off = 0;
  int         m_total = 0;
  int         m_kind = 0;
  logic [7:0] m_din = 8'h00;
  logic [7:0] m_resp = 8'hFF;
  bit         m_dpres = 0;
  logic [7:0] m_res_dout = 8'h00;
  bit         m_res_pres = 0;
  logic [7:0] exp_dout = 8'h00;
  bit         exp_pres = 0;
  string      m_tag = "R2";

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  assign bus_in = !(bus_oe || m_pull);

  owm_master #(.CLK_PER_US(C), .DATA_W(8), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .din(din),
    .dout(dout), .present(present), .busy(busy), .done(done),
    .bus_oe(bus_oe), .bus_in(bus_in)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // expected waveform and device pull for the current model offset
  task automatic model_outputs();
    int s, b, r;
    m_oe = 0; m_pull = 0; m_tag = "R2";
    if (m_active) begin
      if (m_kind == 0) begin
        m_oe = (m_off < 480 * C);
        r = m_off - 480 * C;
        m_pull = m_dpres && r >= 15 * C && r < 135 * C;
      end else begin
        s = m_off % SL;
        b = m_off / SL;
        if (s < 6 * C) begin
          m_oe = 1; m_tag = "R4";
        end else begin
          m_oe = (s < 66 * C) ? !m_din[b] : 0; m_tag = "R5";
        end
        m_pull = s >= C && s < 30 * C && !m_resp[b];
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_done = 0; exp_dout = 8'h00; exp_pres = 0;
    end else begin
      m_done = 0;
      if (m_active) begin
        m_off++;
        if (m_off == m_total) begin
          m_active = 0; m_done = 1;
          exp_dout = m_res_dout; exp_pres = m_res_pres;
        end
      end else if (start && op != 2'b11) begin
        m_active = 1; m_off = 0; m_kind = op; m_din = din;
        m_resp = dev_resp; m_dpres = dev_present;
        m_res_dout = exp_dout; m_res_pres = exp_pres;
        if (op == 2'b00) begin
          m_total = RT; m_res_pres = dev_present;
        end else if (op == 2'b01) begin
          m_total = SL; m_res_dout = {din[0] & dev_resp[0], din[7:1]};
        end else begin
          m_total = 8 * SL; m_res_dout = din & dev_resp;
        end
      end
    end
    model_outputs();
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(m_kind == 0 ? "R2 busy" : "R8 busy", busy, m_active);
      check("R9 done", done, m_done);
      check(m_tag, bus_oe, m_oe);
      if (!m_active) begin
        check(m_kind == 2 ? "R7 dout" : "R6 dout", dout, exp_dout);
        check("R3 present", present, exp_pres);
      end
    end
  end

  task automatic run_op(input logic [1:0] o, input logic [7:0] d);
    @(negedge clk);
    start = 1'b1; op = o; din = d;
    @(negedge clk);
    start = 1'b0;
    while (m_active) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: state after reset
    check("R1 bus_oe", bus_oe, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 dout", dout, 0);
    check("R1 present", present, 0);

    // R2 R3: reset with and without a responding device
    dev_present = 1'b1; run_op(2'b00, 8'h00);
    check("R3 present after answer", present, 1);
    dev_present = 1'b0; run_op(2'b00, 8'h00);
    check("R3 present without answer", present, 0);
    dev_present = 1'b1;

    // R4 R5 R6: single slots
    dev_resp = 8'hFE; run_op(2'b01, 8'hA5);
    check("R6 slot read zero", dout, 8'h52);
    dev_resp = 8'hFF; run_op(2'b01, 8'h00);
    check("R6 slot write zero", dout, 8'h00);
    run_op(2'b01, 8'h0B);
    check("R6 slot read one", dout, 8'h85);

    // R7: byte read and byte write
    dev_resp = 8'h3C; run_op(2'b10, 8'hFF);
    check("R7 byte read", dout, 8'h3C);
    dev_resp = 8'hFF; run_op(2'b10, 8'h81);
    check("R7 byte write", dout, 8'h81);

    // R8: second start with new op and data during a byte
    dev_resp = 8'h5A;
    @(negedge clk);
    start = 1'b1; op = 2'b10; din = 8'hF0;
    @(negedge clk);
    start = 1'b0;
    repeat (150) @(negedge clk);
    start = 1'b1; op = 2'b00; din = 8'h0F;
    @(negedge clk);
    start = 1'b0;
    check("R8 still busy", busy, 1);
    while (m_active) @(negedge clk);
    check("R8 result of first op", dout, 8'h50);
    repeat (3) @(negedge clk);

    // R10: reserved op code does nothing
    @(negedge clk);
    start = 1'b1; op = 2'b11; din = 8'h33;
    @(negedge clk);
    start = 1'b0;
    check("R10 busy", busy, 0);
    check("R10 bus_oe", bus_oe, 0);
    check("R10 dout", dout, 8'h50);
    @(negedge clk);
    check("R10 done", done, 0);
    repeat (5) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule